// File: doc/BRIEF.md
# Serial Slave Pause Gate

This block sits between the synchronized pins of a serial slave port and the command engine behind it, and implements the pause function of the port. The host can freeze a transfer part way through by pulling the active-low pause input low. While the pause holds, the block stops passing clock edges and input-data qualification to the engine, and it withdraws the engine's output drive. The engine's bit counter and shift registers therefore keep their contents, and the transfer carries on from the same bit once the pause is lifted.

All inputs are already synchronized to the system clock `clk`. The block finds serial clock edges by comparing each sample of `sckIn` with the previous one. It passes them to the engine as single-cycle strobes, together with a level that tells the engine when its serial-data input may be sampled. A pause may begin or end only while the serial clock is low. A pause requested while the serial clock is high is deferred to the next falling edge, and that falling edge is absorbed by the pause. The output enable falls at once whenever the pause input is low. After a resume it returns on the following serial-clock-low clock cycle, so the bit the engine presented before the pause is driven again before the next rising edge. Deselecting the slave at any point clears the pause and raises a one-cycle end-of-sequence strobe.

Top module: `spi_hold_gate`

## Requirements
- R1: After reset, no edge strobe, no end-of-sequence strobe and no output enable is asserted, and the gate is in the running state.
- R2: While `csN` is 1, no edge strobe is passed and `soOe` is 0. `seqEnd` is 1 for exactly the one cycle in which `csN` is first sampled 1 after being 0.
- R3: While selected and not paused, each rising serial clock sample (0 to 1) gives `sckRiseStb`=1 and `siValid`=1 in that same cycle, and each falling sample gives `sckFallStb`=1. Both strobes last one cycle.
- R4: In any cycle where `holdN` is 0, `soOe` is 0, whatever the serial clock level and the gate state.
- R5: If `holdN` is sampled 0 while `sckIn` is 0, the pause takes effect in that cycle: no strobe is passed from then on until the pause ends.
- R6: If `holdN` is sampled 0 while `sckIn` is 1, the gate waits. The next falling serial clock edge starts the pause and is not passed as `sckFallStb`.
- R7: A pause ends only in a cycle where `holdN` is 1 and `sckIn` is 0. If `holdN` rises while `sckIn` is 1, the gate stays paused and suppresses edges until the serial clock is low.
- R8: After a resume, `soOe` (with `engSoReq`=1) stays 0 for the first running cycle and returns to 1 in the next running cycle that samples `sckIn`=0.
- R9: Raising `csN` while paused returns the gate to running, with `seqEnd` pulsed. After reselection, edges pass again.
- R10: If `holdN` returns to 1 before the deferred falling edge, no pause occurs and that falling edge is passed as `sckFallStb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Synchronized slave select, active low |
| sckIn | input | 1 | Synchronized serial clock level |
| holdN | input | 1 | Synchronized pause request, active low |
| engSoReq | input | 1 | Engine requests to drive serial output |
| sckRiseStb | output | 1 | Gated rising serial clock strobe to the engine |
| sckFallStb | output | 1 | Gated falling serial clock strobe to the engine |
| siValid | output | 1 | Serial input may be sampled by the engine |
| soOe | output | 1 | Serial output driver enable |
| seqEnd | output | 1 | One-cycle strobe at deselect, ends the engine's sequence |

## Verification
The bench targets the deferred pause: a design that paused at once with the serial clock high would lose the pending falling edge at the wrong point, and one that passed the absorbing falling edge would shift the engine one bit too far. It releases the pause while the serial clock is high. A gate that resumed there would let a stray falling edge through and skew the bit count. It also checks that the output enable is held off for one cycle after a resume, which catches designs that re-enable while still paused or never re-arm. Finally, it cancels a pending pause and deselects in mid-pause. A design that forgot the pending state or kept the pause across a deselect would swallow later edges.

// File: rtl/spi_hold_gate_pkg.sv
package spi_hold_gate_pkg;

  typedef enum logic [1:0] {
    HP_RUN    = 2'd0,
    HP_PEND   = 2'd1,
    HP_PAUSED = 2'd2
  } hpState_t;

  // strobes from the pause control to the edge datapath
  typedef struct packed {
    logic gateOpen;   // edges may pass to the engine
    logic dropFall;   // absorb the falling edge that starts a deferred pause
    logic armClr;     // withdraw output drive arming
    logic armSet;     // re-arm output drive
  } hpCtl_t;

endpackage

// File: rtl/spi_hold_gate_ctrl.sv
module spi_hold_gate_ctrl
  import spi_hold_gate_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   csN,
  input  logic   holdN,
  input  logic   sckIn,
  input  logic   sckFall,
  output hpCtl_t ctl
);

  hpState_t state, stateNxt;
  logic     enterNow;

  assign enterNow = (state == HP_RUN) && !holdN && !sckIn && !csN;

  always_comb begin
    stateNxt = state;
    if (csN) begin
      stateNxt = HP_RUN;
    end else begin
      unique case (state)
        HP_RUN: begin
          if (!holdN) stateNxt = sckIn ? HP_PEND : HP_PAUSED;
        end
        HP_PEND: begin
          if (sckFall) stateNxt = holdN ? HP_RUN : HP_PAUSED;
        end
        HP_PAUSED: begin
          if (holdN && !sckIn) stateNxt = HP_RUN;
        end
        default: stateNxt = HP_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= HP_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    ctl.gateOpen = !csN && (state != HP_PAUSED) && !enterNow;
    ctl.dropFall = (state == HP_PEND) && !holdN;
    ctl.armClr   = csN || (state == HP_PAUSED) || enterNow;
    ctl.armSet   = (state == HP_RUN) && !sckIn && holdN && !csN;
  end

  // R5: pause begins at once when requested with the serial clock low
  p_pause_on_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == HP_RUN && !holdN && !sckIn && !csN) |=> (state == HP_PAUSED));

  // R6: a deferred pause waits while the serial clock stays high
  p_pending_waits_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == HP_PEND && sckIn && !csN) |=> (state == HP_PEND));

  // R7: no resume while the serial clock is high
  p_no_resume_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == HP_PAUSED && sckIn && !csN) |=> (state == HP_PAUSED));

  // R9: deselect always returns to running
  p_deselect_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (state == HP_RUN));

endmodule

// File: rtl/spi_hold_gate_dp.sv
module spi_hold_gate_dp
  import spi_hold_gate_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   csN,
  input  logic   sckIn,
  input  logic   holdN,
  input  logic   engSoReq,
  input  hpCtl_t ctl,
  output logic   sckFall,
  output logic   sckRiseStb,
  output logic   sckFallStb,
  output logic   siValid,
  output logic   soOe,
  output logic   seqEnd
);

  logic sckQ;
  logic csQ;
  logic soArm;
  logic sckRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ  <= 1'b0;
      csQ   <= 1'b1;
      soArm <= 1'b0;
    end else begin
      sckQ <= sckIn;
      csQ  <= csN;
      if (ctl.armClr)      soArm <= 1'b0;
      else if (ctl.armSet) soArm <= 1'b1;
    end
  end

  assign sckRise    = sckIn && !sckQ;
  assign sckFall    = !sckIn && sckQ;
  assign siValid    = ctl.gateOpen;
  assign sckRiseStb = sckRise && ctl.gateOpen;
  assign sckFallStb = sckFall && ctl.gateOpen && !ctl.dropFall;
  assign soOe       = soArm && holdN && !csN && engSoReq;
  assign seqEnd     = csN && !csQ;

  // R2: end-of-sequence strobe lasts a single cycle
  p_seqend_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    seqEnd |=> !seqEnd);

  // R3: a passed rising strobe is never repeated on the next cycle
  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    sckRiseStb |=> !sckRiseStb);

  // R4: pause request silences the output driver
  p_so_off_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !holdN |-> !soOe);

  // R2: nothing reaches the engine while deselected
  p_quiet_deselect_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !(sckRiseStb || sckFallStb || soOe));

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import spi_hold_gate_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sckIn,
  input  logic holdN,
  input  logic engSoReq,
  output logic sckRiseStb,
  output logic sckFallStb,
  output logic siValid,
  output logic soOe,
  output logic seqEnd
);

  hpCtl_t ctl;
  logic   sckFall;

  spi_hold_gate_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .holdN   (holdN),
    .sckIn   (sckIn),
    .sckFall (sckFall),
    .ctl     (ctl)
  );

  spi_hold_gate_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .sckIn      (sckIn),
    .holdN      (holdN),
    .engSoReq   (engSoReq),
    .ctl        (ctl),
    .sckFall    (sckFall),
    .sckRiseStb (sckRiseStb),
    .sckFallStb (sckFallStb),
    .siValid    (siValid),
    .soOe       (soOe),
    .seqEnd     (seqEnd)
  );

  // R3: the two edge strobes never coincide
  p_one_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(sckRiseStb && sckFallStb));

endmodule

// File: tb/spi_hold_gate_bench.sv
module spi_hold_gate_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sckIn = 1'b0;
  logic holdN = 1'b1;
  logic engSoReq = 1'b1;
  logic sckRiseStb, sckFallStb, siValid, soOe, seqEnd;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_hold_gate u_spi_hold_gate (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .sckIn      (sckIn),
    .holdN      (holdN),
    .engSoReq   (engSoReq),
    .sckRiseStb (sckRiseStb),
    .sckFallStb (sckFallStb),
    .siValid    (siValid),
    .soOe       (soOe),
    .seqEnd     (seqEnd)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // apply pins after a falling clock edge, then settle
  task automatic drive(input logic cs, input logic sck, input logic hold);
    @(negedge clk);
    csN = cs; sckIn = sck; holdN = hold;
    #1;
  endtask

  task automatic t_reset;
    chk("R1", "soOe in reset", soOe, 1'b0);
    chk("R1", "rise in reset", sckRiseStb, 1'b0);
    chk("R1", "seqEnd in reset", seqEnd, 1'b0);
    @(negedge clk); rstN = 1'b1;
    drive(1, 1, 1);
    chk("R2", "rise while deselected", sckRiseStb, 1'b0);
    drive(1, 0, 1);
    chk("R2", "fall while deselected", sckFallStb, 1'b0);
    chk("R2", "soOe while deselected", soOe, 1'b0);
  endtask

  task automatic t_run;
    drive(0, 0, 1);
    drive(0, 0, 1);
    chk("R3", "soOe armed when running", soOe, 1'b1);
    drive(0, 1, 1);
    chk("R3", "rise passed", sckRiseStb, 1'b1);
    chk("R3", "siValid on rise", siValid, 1'b1);
    drive(0, 1, 1);
    chk("R3", "rise lasts one cycle", sckRiseStb, 1'b0);
    drive(0, 0, 1);
    chk("R3", "fall passed", sckFallStb, 1'b1);
  endtask

  task automatic t_pause_low;
    drive(0, 0, 0);
    chk("R4", "soOe off at pause", soOe, 1'b0);
    chk("R5", "siValid off at pause", siValid, 1'b0);
    drive(0, 1, 0);
    chk("R5", "rise blocked while paused", sckRiseStb, 1'b0);
    drive(0, 0, 0);
    chk("R5", "fall blocked while paused", sckFallStb, 1'b0);
  endtask

  task automatic t_release_high;
    drive(0, 1, 0);
    drive(0, 1, 1);
    chk("R7", "rise blocked after late release", sckRiseStb, 1'b0);
    drive(0, 0, 1);
    chk("R7", "fall blocked before resume", sckFallStb, 1'b0);
    drive(0, 1, 1);
    chk("R7", "rise passes after resume", sckRiseStb, 1'b1);
    drive(0, 0, 1);
  endtask

  task automatic t_resume_so;
    drive(0, 0, 0);
    drive(0, 0, 1);
    chk("R8", "soOe off on resume cycle", soOe, 1'b0);
    drive(0, 0, 1);
    chk("R8", "soOe off first running cycle", soOe, 1'b0);
    drive(0, 0, 1);
    chk("R8", "soOe restored", soOe, 1'b1);
  endtask

  task automatic t_pause_high;
    drive(0, 1, 1);
    chk("R6", "rise before deferred pause", sckRiseStb, 1'b1);
    drive(0, 1, 0);
    chk("R4", "soOe off with clock high", soOe, 1'b0);
    drive(0, 0, 0);
    chk("R6", "pause-starting fall absorbed", sckFallStb, 1'b0);
    drive(0, 1, 0);
    chk("R6", "rise blocked after deferred pause", sckRiseStb, 1'b0);
    drive(0, 0, 0);
    drive(0, 0, 1);
    drive(0, 0, 1);
  endtask

  task automatic t_cancel_pending;
    drive(0, 1, 1);
    drive(0, 1, 0);
    drive(0, 1, 1);
    drive(0, 0, 1);
    chk("R10", "fall passes after cancelled pause", sckFallStb, 1'b1);
    drive(0, 1, 1);
    chk("R10", "rise passes after cancelled pause", sckRiseStb, 1'b1);
    drive(0, 0, 1);
  endtask

  task automatic t_deselect_pause;
    drive(0, 0, 0);
    drive(1, 0, 0);
    chk("R9", "seqEnd at deselect", seqEnd, 1'b1);
    drive(1, 0, 1);
    chk("R2", "seqEnd single cycle", seqEnd, 1'b0);
    drive(0, 0, 1);
    drive(0, 1, 1);
    chk("R9", "rise passes after reselect", sckRiseStb, 1'b1);
    drive(0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_run();
    t_pause_low();
    t_release_high();
    t_resume_so();
    t_pause_high();
    t_cancel_pending();
    t_deselect_pause();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule